// File: doc/BRIEF.md
# XY Dimension-Order Route Unit

This block computes the output port for packets held in one input buffer of a mesh router. It looks at the flit at the head of the buffer. When that flit is a packet header, the block takes the destination node number from it and converts it into a column and a row in a row-major mesh. It then compares that position with the router's own position, which is fixed by parameters. The result is a one-hot request for one of five ports: Local, North, East, South or West. The column is always settled before the row is considered, so a packet moves along X first and then along Y.

Switching is wormhole style, so the decision is registered when the header is seen. It stays fixed for the body and tail flits that follow, until a tail flit leaves the buffer. The buffer side of the interface works like a valid/ready stream. `head_vld` says a flit is present. `head_pop` is the ready side: the buffer drains a flit only in a cycle where both are high. If `head_pop` stays low, the head flit stays in place for as long as needed, and the route is held for that time. A header with the reserved type, or with a destination beyond the mesh, gets no route and raises `route_err`.

Top module: `xy_route_unit`

## Requirements
- R1: A flit is split into kind in [11:10] (00 header, 01 body, 10 tail, 11 reserved), source in [9:5] and destination in [4:0]. Destination node n sits at column n mod MESH_COLS and row n div MESH_COLS, with row 0 at the top.
- R2: If the destination column is below the router's own column, the route is West. If it is above, the route is East. The rows do not matter in either case.
- R3: When the columns are equal, a smaller destination row routes North, a larger one routes South, and an equal one routes Local.
- R4: `route_req` is one-hot or zero, with bit 0 Local, bit 1 North, bit 2 East, bit 3 South and bit 4 West. It is zero when nothing is held and `head_vld` is low.
- R5: When no route is held and a valid in-mesh header is at the head, its route appears on `route_req` in the same cycle. `route_locked` rises after the next clock edge.
- R6: While `route_locked` is high, `route_req` keeps the captured route. Whatever sits at the head, including new headers, does not change it unless a tail is popped.
- R7: Popping a tail flit (`head_vld` and `head_pop` high, kind 10) while locked clears `route_locked` after the edge. A tail at the head that is not popped releases nothing.
- R8: A valid header whose destination is MESH_ROWS*MESH_COLS or above gives `route_req` zero and `route_err` high in that cycle, and it takes no lock. A valid reserved-kind flit raises `route_err` in any state.
- R9: A body or tail flit at the head while nothing is held gives zero route, no error and no lock.
- R10: After reset, `route_locked` is low and `route_req` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| head_vld | input | 1 | A flit is present at the buffer head |
| head_flit | input | FLIT_W | Flit at the buffer head |
| head_pop | input | 1 | The buffer drains the head flit this cycle (when head_vld) |
| route_req | output | 5 | One-hot requested output port |
| route_locked | output | 1 | A packet route is being held |
| route_err | output | 1 | Reserved kind, or header destination outside the mesh |

## Verification
Two functions can fall in the same cycle: the held route, and error detection on a reserved-kind flit that shows up at the head in the middle of a packet. The bench locks an East route and then places a reserved flit at the head. It expects `route_err` high and `route_req` still East in that same cycle. The bench also checks that a tail pop and a new header capture happen one after the other: a header presented in the cycle right after the tail pop must show its own route at once.

// File: rtl/xyr_pkg.sv
package xyr_pkg;
  typedef enum logic [1:0] {
    FK_HEAD = 2'b00,
    FK_BODY = 2'b01,
    FK_TAIL = 2'b10,
    FK_RSVD = 2'b11
  } flit_kind_e;

  localparam int PORT_N  = 5;
  localparam int P_LOCAL = 0;
  localparam int P_NORTH = 1;
  localparam int P_EAST  = 2;
  localparam int P_SOUTH = 3;
  localparam int P_WEST  = 4;
endpackage

// File: rtl/xyr_addr_decode.sv
module xyr_addr_decode #(
  parameter int ADDR_W    = 5,
  parameter int MESH_ROWS = 4,
  parameter int MESH_COLS = 4
) (
  input  logic [ADDR_W-1:0] node,
  output logic [ADDR_W-1:0] col,
  output logic [ADDR_W-1:0] row,
  output logic              in_mesh
);
  localparam int              NODES  = MESH_ROWS * MESH_COLS;
  localparam logic [ADDR_W-1:0] COLS_V = ADDR_W'(MESH_COLS);

  // row-major numbering: column is the remainder, row the quotient
  always_comb begin
    col     = node % COLS_V;
    row     = node / COLS_V;
    in_mesh = (32'(node) < 32'(NODES));
  end
endmodule

// File: rtl/xyr_dir_select.sv
module xyr_dir_select
  import xyr_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int OWN_COL = 1,
  parameter int OWN_ROW = 1
) (
  input  logic [ADDR_W-1:0] dst_col,
  input  logic [ADDR_W-1:0] dst_row,
  output logic [PORT_N-1:0] dir_oh
);
  localparam logic [ADDR_W-1:0] OC = ADDR_W'(OWN_COL);
  localparam logic [ADDR_W-1:0] OR = ADDR_W'(OWN_ROW);

  // X settled fully before Y is looked at
  always_comb begin
    dir_oh = '0;
    if (dst_col < OC)       dir_oh[P_WEST]  = 1'b1;
    else if (dst_col > OC)  dir_oh[P_EAST]  = 1'b1;
    else if (dst_row < OR)  dir_oh[P_NORTH] = 1'b1;
    else if (dst_row > OR)  dir_oh[P_SOUTH] = 1'b1;
    else                    dir_oh[P_LOCAL] = 1'b1;
  end
endmodule

// File: rtl/xyr_route_hold.sv
module xyr_route_hold
  import xyr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              head_vld,
  input  logic              head_pop,
  input  logic              is_head,
  input  logic              is_tail,
  input  logic              hdr_ok,
  input  logic [PORT_N-1:0] dir_oh,
  output logic [PORT_N-1:0] route_req,
  output logic              locked
);
  logic [PORT_N-1:0] held_q;
  logic              capture;
  logic              release_pkt;

  assign capture     = !locked && head_vld && is_head && hdr_ok;
  assign release_pkt = locked && head_vld && head_pop && is_tail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b0;
      held_q <= '0;
    end else if (capture) begin
      locked <= 1'b1;
      held_q <= dir_oh;
    end else if (release_pkt) begin
      locked <= 1'b0;
      held_q <= '0;
    end
  end

  always_comb begin
    if (locked)       route_req = held_q;
    else if (capture) route_req = dir_oh;
    else              route_req = '0;
  end

  // R5
  lock_on_header_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && head_vld && is_head && hdr_ok) |=> locked);

  // R6
  route_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !(head_vld && head_pop && is_tail)) |=> (locked && $stable(route_req)));

  // R7
  tail_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && head_vld && head_pop && is_tail) |=> !locked);

  // R9
  no_lock_midpkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && !(head_vld && is_head)) |=> !locked);
endmodule

// File: rtl/xy_route_unit.sv
module xy_route_unit
  import xyr_pkg::*;
#(
  parameter int MESH_ROWS = 4,
  parameter int MESH_COLS = 4,
  parameter int ADDR_W    = 5,
  parameter int FLIT_W    = 12,
  parameter int NODE_ID   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              head_vld,
  input  logic [FLIT_W-1:0] head_flit,
  input  logic              head_pop,
  output logic [4:0]        route_req,
  output logic              route_locked,
  output logic              route_err
);
  localparam int OWN_COL = NODE_ID % MESH_COLS;
  localparam int OWN_ROW = NODE_ID / MESH_COLS;
  localparam int KIND_LO = FLIT_W - 2;

  flit_kind_e        kind;
  logic [ADDR_W-1:0] dst_node, dst_col, dst_row;
  logic              dst_in_mesh;
  logic [PORT_N-1:0] dir_oh;
  logic              is_head, is_tail, hdr_ok;

  assign kind     = flit_kind_e'(head_flit[FLIT_W-1:KIND_LO]);
  assign dst_node = head_flit[ADDR_W-1:0];
  assign is_head  = (kind == FK_HEAD);
  assign is_tail  = (kind == FK_TAIL);
  assign hdr_ok   = is_head && dst_in_mesh;

  xyr_addr_decode #(
    .ADDR_W(ADDR_W), .MESH_ROWS(MESH_ROWS), .MESH_COLS(MESH_COLS)
  ) u_dec (
    .node(dst_node), .col(dst_col), .row(dst_row), .in_mesh(dst_in_mesh)
  );

  xyr_dir_select #(
    .ADDR_W(ADDR_W), .OWN_COL(OWN_COL), .OWN_ROW(OWN_ROW)
  ) u_dir (
    .dst_col(dst_col), .dst_row(dst_row), .dir_oh(dir_oh)
  );

  xyr_route_hold u_hold (
    .clk(clk), .rst_n(rst_n), .head_vld(head_vld), .head_pop(head_pop),
    .is_head(is_head), .is_tail(is_tail), .hdr_ok(hdr_ok), .dir_oh(dir_oh),
    .route_req(route_req), .locked(route_locked)
  );

  assign route_err = head_vld &&
                     ((kind == FK_RSVD) || (!route_locked && is_head && !dst_in_mesh));

  // R4
  onehot_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(route_req));

  // R8
  err_no_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (route_err && !route_locked) |-> (route_req == '0));

  // R8
  err_no_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (route_err && !route_locked) |=> !route_locked);
endmodule

// File: tb/xy_route_unit_bench.sv
`timescale 1ns/1ps
module xy_route_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        head_vld = 1'b0;
  logic [11:0] head_flit = '0;
  logic        head_pop = 1'b0;
  logic [4:0]  route_req;
  logic        route_locked;
  logic        route_err;

  int n_run = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  xy_route_unit u_xy_route_unit (
    .clk(clk), .rst_n(rst_n), .head_vld(head_vld), .head_flit(head_flit),
    .head_pop(head_pop), .route_req(route_req), .route_locked(route_locked),
    .route_err(route_err)
  );

  localparam logic [4:0] LOC = 5'b00001, NOR = 5'b00010, EAS = 5'b00100,
                         SOU = 5'b01000, WES = 5'b10000, NON = 5'b00000;

  // {kind, dest, expected route, expected error}; router is node 5 (col 1, row 1)
  localparam logic [12:0] VEC [13] = '{
    {2'b00, 5'd5,  LOC, 1'b0},
    {2'b00, 5'd4,  WES, 1'b0},
    {2'b00, 5'd6,  EAS, 1'b0},
    {2'b00, 5'd1,  NOR, 1'b0},
    {2'b00, 5'd9,  SOU, 1'b0},
    {2'b00, 5'd0,  WES, 1'b0},
    {2'b00, 5'd15, EAS, 1'b0},
    {2'b00, 5'd13, SOU, 1'b0},
    {2'b00, 5'd3,  EAS, 1'b0},
    {2'b00, 5'd12, WES, 1'b0},
    {2'b00, 5'd16, NON, 1'b1},
    {2'b00, 5'd31, NON, 1'b1},
    {2'b11, 5'd6,  NON, 1'b1}
  };

  task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic put(input logic v, input logic [1:0] k, input logic [4:0] d, input logic p);
    @(negedge clk);
    head_vld  = v;
    head_flit = {k, 5'd3, d};
    head_pop  = p;
    #1;
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R10 reset route", route_req, NON);
    chk("R10 reset locked", {4'b0, route_locked}, 5'd0);
    rst_n = 1'b1;

    // table walk: header, then popped tail, then empty head
    foreach (VEC[i]) begin
      put(1'b1, VEC[i][12:11], VEC[i][10:6], 1'b1);
      chk($sformatf("R1 R2 R3 vec%0d route", i), route_req, VEC[i][5:1]);
      chk($sformatf("R8 vec%0d err", i), {4'b0, route_err}, {4'b0, VEC[i][0]});
      put(1'b1, 2'b10, 5'd0, 1'b1);
      chk($sformatf("R5 vec%0d held", i), route_req, VEC[i][5:1]);
      chk($sformatf("R5 R8 vec%0d lock", i), {4'b0, route_locked}, {4'b0, !VEC[i][0]});
      put(1'b0, 2'b00, 5'd0, 1'b0);
      chk($sformatf("R7 vec%0d released", i), {route_locked, route_req[3:0]}, 5'd0);
    end

    // R4: header bits but no valid
    put(1'b0, 2'b00, 5'd6, 1'b0);
    chk("R4 invalid head gives no route", route_req, NON);
    // R9: body and tail while idle
    put(1'b1, 2'b01, 5'd6, 1'b1);
    chk("R9 body idle route", route_req, NON);
    chk("R9 body idle err", {4'b0, route_err}, 5'd0);
    put(1'b1, 2'b10, 5'd6, 1'b0);
    chk("R9 body did not lock", {4'b0, route_locked}, 5'd0);
    chk("R9 tail idle route", route_req, NON);

    // hold sequence
    put(1'b1, 2'b00, 5'd6, 1'b0);
    chk("R5 east presented", route_req, EAS);
    put(1'b1, 2'b00, 5'd9, 1'b0);
    chk("R6 new header ignored", route_req, EAS);
    chk("R5 locked", {4'b0, route_locked}, 5'd1);
    put(1'b1, 2'b01, 5'd1, 1'b1);
    chk("R6 body popped route", route_req, EAS);
    put(1'b1, 2'b11, 5'd1, 1'b0);
    chk("R8 reserved mid-packet err", {4'b0, route_err}, 5'd1);
    chk("R6 reserved mid-packet route", route_req, EAS);
    put(1'b1, 2'b10, 5'd1, 1'b0);
    chk("R7 unpopped tail holds", route_req, EAS);
    put(1'b1, 2'b10, 5'd1, 1'b1);
    chk("R7 tail pop cycle route", route_req, EAS);
    put(1'b1, 2'b00, 5'd1, 1'b0);
    chk("R7 unlocked after tail", {4'b0, route_locked}, 5'd0);
    chk("R3 next header north at once", route_req, NOR);
    put(1'b0, 2'b00, 5'd0, 1'b0);
    chk("R5 north held", route_req, NOR);

    // reset clears a held route
    rst_n = 1'b0;
    #1;
    chk("R10 reset clears hold", {route_locked, route_req[3:0]}, 5'd0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule